// File: doc/BRIEF.md
# Translation Table Pointer Generator

This block holds the state that a page-miss handler needs to locate a candidate entry in an in-memory translation table. It keeps a faulting-tag register, made of a virtual page number and a 13-bit context number, and two register banks. Each bank has a table base register and a configuration register. One bank serves context number zero and the other serves every non-zero context. From these registers the block forms a table entry pointer for each of two page-size classes, with no clock delay.

Software or a refill engine writes the registers through a one-cycle address/data write port. It reads the registers, a reformatted view of the tag, and the two pointers through a combinational read port. The table may be split: the class-1 half then sits directly above the class-0 half, and the class-1 pointer gains one address bit whose position depends on the table size.

Top module: `ttptr_top`

## Requirements
- R1: After reset every register reads back as zero, and both pointers and the formatted tag read as zero.
- R2: A write with `wrEn` high lands on the next rising clock edge in the register at its address: 1 = tag, 2 = zero-context base, 3 = zero-context config, 4 = non-zero-context base, 5 = non-zero-context config. Each of these reads back unchanged at its own address.
- R3: Writes to the read-only addresses 0, 6 and 7 change no register.
- R4: Pointer generation uses the zero-context bank when tag bits [12:0] are all zero, and the non-zero-context bank otherwise. Tag bits above bit 12 play no part in this choice.
- R5: Pointer bits [63:13] start from the selected base bits [63:13].
- R6: The pointer ORs in the tag shifted right by 9 + 3·p and kept only over bits [12+s:4]. Here s is base bits [3:0], and p is config bits [2:0] for class 0 (address 6) or config bits [10:8] for class 1 (address 7). Pointer bits [3:0] are zero.
- R7: When base bit 12 (split) is set, the class-1 pointer also ORs in a one at bit 13+s. The class-0 pointer is unaffected by split.
- R8: Address 0 reads tag bits [63:22] in bits [41:0] and tag bits [12:0] in bits [60:48], with all other bits zero.
- R9: `rdData` follows `rdAddr` and the register contents within the same cycle, so a pointer reflects a write from the first cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 3 | Write register address |
| wrData | input | 64 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 64 | Read data, combinational |

## Verification
Two cases are hard to reach with uniform random data. One is a tag whose context field is exactly zero while its page bits are not. The other is a context that is non-zero only in bit 0 or only in bit 12, which is where the bank choice could be wrongly decoded. The random tag writes clear the context field in about a third of cases. Directed steps then place a single set context bit at each end of the field. A second hard corner is the largest table size together with the largest page code, where the shift and the mask reach their widest reach. This corner is driven directly, with and without the split flag.

// File: rtl/ttptr_pkg.sv
package ttptr_pkg;
  localparam int REG_W     = 64;
  localparam int ADDR_W    = 3;
  localparam int CTX_W     = 13;
  localparam int PAGE_LSB  = 13;
  localparam int SPLIT_BIT = 12;
  localparam int SIZE_W    = 4;
  localparam int PCODE_W   = 3;
  localparam int IDX_BASE  = 9;
  localparam int IDX_LSB   = 4;
  localparam int FMT_VA_LSB  = 22;
  localparam int FMT_CTX_LSB = 48;
  localparam int SH_W      = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TAG_VIEW = 3'd0,
    ADDR_TAG      = 3'd1,
    ADDR_Z_BASE   = 3'd2,
    ADDR_Z_CFG    = 3'd3,
    ADDR_N_BASE   = 3'd4,
    ADDR_N_CFG    = 3'd5,
    ADDR_PTR_C0   = 3'd6,
    ADDR_PTR_C1   = 3'd7
  } regAddrE;

  typedef struct packed {
    logic    wrTag;
    logic    wrZBase;
    logic    wrZCfg;
    logic    wrNBase;
    logic    wrNCfg;
    regAddrE rdSel;
  } strobeT;
endpackage

// File: rtl/ttptr_ctrl.sv
module ttptr_ctrl
  import ttptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobeT            strb
);
  regAddrE wrSel;
  assign wrSel = regAddrE'(wrAddr);

  always_comb begin
    strb         = '0;
    strb.rdSel   = regAddrE'(rdAddr);
    if (wrEn) begin
      case (wrSel)
        ADDR_TAG:    strb.wrTag   = 1'b1;
        ADDR_Z_BASE: strb.wrZBase = 1'b1;
        ADDR_Z_CFG:  strb.wrZCfg  = 1'b1;
        ADDR_N_BASE: strb.wrNBase = 1'b1;
        ADDR_N_CFG:  strb.wrNCfg  = 1'b1;
        default: ;
      endcase
    end
  end

  logic [4:0] wrVec;
  assign wrVec = {strb.wrTag, strb.wrZBase, strb.wrZCfg, strb.wrNBase, strb.wrNCfg};

  // R2: at most one register is written per cycle, and only when wrEn is high
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec) && (!wrEn -> (wrVec == '0)));

  // R3: read-only addresses never raise a write strobe
  p_ro_no_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == 3'd0 || wrAddr == 3'd6 || wrAddr == 3'd7)) |-> (wrVec == '0));
endmodule

// File: rtl/ttptr_calc.sv
module ttptr_calc
  import ttptr_pkg::*;
#(
  parameter bit CLASS_ONE = 1'b0
)(
  input  logic [REG_W-1:PAGE_LSB] baseHi,
  input  logic                    splitEn,
  input  logic [SIZE_W-1:0]       sizeCode,
  input  logic [PCODE_W-1:0]      pageCode,
  input  logic [REG_W-1:0]        tagIn,
  output logic [REG_W-1:0]        ptrOut
);
  logic [SH_W-1:0]  shAmt;
  logic [SH_W-1:0]  topPos;
  logic [REG_W-1:0] idxMask;
  logic [REG_W-1:0] idxBits;
  logic [REG_W-1:0] splitBit;

  assign shAmt   = SH_W'(IDX_BASE) + SH_W'(pageCode) * SH_W'(3);
  assign topPos  = SH_W'(sizeCode) + SH_W'(PAGE_LSB);
  assign idxMask = ((REG_W'(1) << topPos) - REG_W'(1)) & ~((REG_W'(1) << IDX_LSB) - REG_W'(1));
  assign idxBits = (tagIn >> shAmt) & idxMask;

  generate
    if (CLASS_ONE) begin : g_split
      assign splitBit = splitEn ? (REG_W'(1) << topPos) : '0;
    end else begin : g_nosplit
      logic unusedSplit;
      assign unusedSplit = splitEn;
      assign splitBit    = '0;
    end
  endgenerate

  assign ptrOut = {baseHi, {PAGE_LSB{1'b0}}} | idxBits | splitBit;
endmodule

// File: rtl/ttptr_dpath.sv
module ttptr_dpath
  import ttptr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData
);
  logic [REG_W-1:0] tagQ, zBaseQ, zCfgQ, nBaseQ, nCfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagQ   <= '0;
      zBaseQ <= '0;
      zCfgQ  <= '0;
      nBaseQ <= '0;
      nCfgQ  <= '0;
    end else begin
      if (strb.wrTag)   tagQ   <= wrData;
      if (strb.wrZBase) zBaseQ <= wrData;
      if (strb.wrZCfg)  zCfgQ  <= wrData;
      if (strb.wrNBase) nBaseQ <= wrData;
      if (strb.wrNCfg)  nCfgQ  <= wrData;
    end
  end

  // bank choice from the context field of the tag
  logic             ctxZero;
  logic [REG_W-1:0] selBase, selCfg;
  assign ctxZero = (tagQ[CTX_W-1:0] == '0);
  assign selBase = ctxZero ? zBaseQ : nBaseQ;
  assign selCfg  = ctxZero ? zCfgQ  : nCfgQ;

  logic [REG_W-1:0] ptrVec [2];
  generate
    for (genvar c = 0; c < 2; c++) begin : g_class
      ttptr_calc #(.CLASS_ONE(c == 1)) i_calc (
        .baseHi  (selBase[REG_W-1:PAGE_LSB]),
        .splitEn (selBase[SPLIT_BIT]),
        .sizeCode(selBase[SIZE_W-1:0]),
        .pageCode((c == 1) ? selCfg[10:8] : selCfg[2:0]),
        .tagIn   (tagQ),
        .ptrOut  (ptrVec[c])
      );
    end
  endgenerate

  logic [REG_W-1:0] tagView;
  assign tagView = {{(REG_W-FMT_CTX_LSB-CTX_W){1'b0}}, tagQ[CTX_W-1:0],
                    {(FMT_CTX_LSB-(REG_W-FMT_VA_LSB)){1'b0}}, tagQ[REG_W-1:FMT_VA_LSB]};

  always_comb begin
    case (strb.rdSel)
      ADDR_TAG_VIEW: rdData = tagView;
      ADDR_TAG:      rdData = tagQ;
      ADDR_Z_BASE:   rdData = zBaseQ;
      ADDR_Z_CFG:    rdData = zCfgQ;
      ADDR_N_BASE:   rdData = nBaseQ;
      ADDR_N_CFG:    rdData = nCfgQ;
      ADDR_PTR_C0:   rdData = ptrVec[0];
      ADDR_PTR_C1:   rdData = ptrVec[1];
      default:       rdData = '0;
    endcase
  end

  // R2: a tag write is visible on the following cycle
  p_tag_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTag |=> (tagQ == $past(wrData)));

  // R3: with no strobe, all registers hold
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrTag || strb.wrZBase || strb.wrZCfg || strb.wrNBase || strb.wrNCfg)
    |=> ($stable(tagQ) && $stable(zBaseQ) && $stable(zCfgQ) && $stable(nBaseQ) && $stable(nCfgQ)));

  // R6/R7: equal page codes and no split make both class pointers agree
  p_classes_agree_r6: assert property (@(posedge clk) disable iff (!rstN)
    (selCfg[2:0] == selCfg[10:8] && !selBase[SPLIT_BIT]) |-> (ptrVec[0] == ptrVec[1]));

  // R6: low four pointer bits are never set
  p_low_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ptrVec[0][3:0] == 4'd0) && (ptrVec[1][3:0] == 4'd0));

  // R8: the gap fields of the tag view read zero
  p_view_gaps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == ADDR_TAG_VIEW) |-> (rdData[47:42] == '0 && rdData[63:61] == '0));
endmodule

// File: rtl/ttptr_top.sv
module ttptr_top
  import ttptr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData
);
  strobeT strb;

  ttptr_ctrl i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .strb  (strb)
  );

  ttptr_dpath i_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wrData(wrData),
    .rdData(rdData)
  );
endmodule

// File: tb/test_ttptr_top.sv
module test_ttptr_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [63:0] rdData;

  int vectors = 0;
  int misses  = 0;

  logic [63:0] mTag = '0, mZB = '0, mZC = '0, mNB = '0, mNC = '0;

  ttptr_top i_ttptr_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] expPtr(input bit cls1);
    logic [63:0] b, c, e;
    int s, p;
    b = (mTag[12:0] == 13'd0) ? mZB : mNB;
    c = (mTag[12:0] == 13'd0) ? mZC : mNC;
    s = int'(b[3:0]);
    p = cls1 ? int'(c[10:8]) : int'(c[2:0]);
    e = '0;
    for (int k = 13; k < 64; k++) e[k] = b[k];
    for (int k = 4; k <= 12 + s; k++) begin
      if (k + 9 + 3 * p < 64) e[k] = e[k] | mTag[k + 9 + 3 * p];
    end
    if (cls1 && b[12]) e[13 + s] = 1'b1;
    return e;
  endfunction

  function automatic logic [63:0] expView();
    logic [63:0] e;
    e = '0;
    for (int k = 22; k < 64; k++) e[k - 22] = mTag[k];
    for (int k = 0; k < 13; k++) e[48 + k] = mTag[k];
    return e;
  endfunction

  function automatic logic [63:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return expView();
      3'd1: return mTag;
      3'd2: return mZB;
      3'd3: return mZC;
      3'd4: return mNB;
      3'd5: return mNC;
      3'd6: return expPtr(1'b0);
      default: return expPtr(1'b1);
    endcase
  endfunction

  task automatic checkRd(input logic [2:0] a, input string req);
    logic [63:0] e;
    rdAddr = a;
    #1;
    e = expRead(a);
    vectors++;
    if (rdData !== e) begin
      misses++;
      $display("FAIL %s addr=%0d actual=%h expected=%h", req, a, rdData, e);
    end
  endtask

  task automatic checkAll(input string req);
    for (int a = 0; a < 8; a++) checkRd(3'(a), req);
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    case (a)
      3'd1: mTag = d;
      3'd2: mZB  = d;
      3'd3: mZC  = d;
      3'd4: mNB  = d;
      3'd5: mNC  = d;
      default: ;
    endcase
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R5: base upper bits pass through with zero tag
    doWrite(3'd2, 64'hA5C3_0F1E_7777_E000);
    checkRd(3'd6, "R5");
    checkRd(3'd7, "R5");
    checkRd(3'd2, "R2");

    // R4: context zero vs bit 0 vs bit 12, tag bit 13 ignored for choice
    doWrite(3'd4, 64'h1234_5678_9ABC_0003);
    doWrite(3'd5, 64'h0000_0000_0000_0201);
    doWrite(3'd3, 64'h0000_0000_0000_0102);
    doWrite(3'd1, 64'h0000_0FFF_FFFF_2000);
    checkRd(3'd6, "R4"); checkRd(3'd7, "R4");
    doWrite(3'd1, 64'h0000_0FFF_FFFF_2001);
    checkRd(3'd6, "R4"); checkRd(3'd7, "R4");
    doWrite(3'd1, 64'h0000_0FFF_FFFF_3000);
    checkRd(3'd6, "R4"); checkRd(3'd7, "R4");

    // R6 widest reach: size 15, page code 7, all-ones tag
    doWrite(3'd4, 64'hFFFF_0000_0000_000F);
    doWrite(3'd5, 64'h0000_0000_0000_0707);
    doWrite(3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    checkRd(3'd6, "R6"); checkRd(3'd7, "R6");
    // R6 narrowest: size 0, page code 0
    doWrite(3'd4, 64'h0000_0000_0000_0000);
    doWrite(3'd5, 64'h0000_0000_0000_0000);
    checkRd(3'd6, "R6"); checkRd(3'd7, "R6");

    // R7: split with size 15 and size 0
    doWrite(3'd4, 64'h8000_0000_0000_100F);
    checkRd(3'd6, "R7"); checkRd(3'd7, "R7");
    doWrite(3'd4, 64'h8000_0000_0000_1000);
    checkRd(3'd6, "R7"); checkRd(3'd7, "R7");

    // R8: tag view
    doWrite(3'd1, 64'hDEAD_BEEF_CAFE_1ABC);
    checkRd(3'd0, "R8");

    // R3: writes to read-only addresses leave all registers alone
    doWrite(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    doWrite(3'd6, 64'h0123_4567_89AB_CDEF);
    doWrite(3'd7, 64'hFEDC_BA98_7654_3210);
    checkAll("R3");

    // R9: read port follows address within one cycle
    @(negedge clk);
    for (int a = 7; a >= 0; a--) checkRd(3'(a), "R9");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  a;
      logic [63:0] d;
      a = 3'($urandom_range(0, 7));
      d = rnd64();
      if (a == 3'd1 && $urandom_range(0, 2) == 0) d[12:0] = '0;
      if ((a == 3'd2 || a == 3'd4) && $urandom_range(0, 3) == 0) d[3:0] = 4'hF;
      doWrite(a, d);
      checkRd(3'd0, "R8");
      checkRd(3'd1, "R2");
      checkRd(3'd2, "R2");
      checkRd(3'd3, "R2");
      checkRd(3'd4, "R2");
      checkRd(3'd5, "R2");
      checkRd(3'd6, "R6");
      checkRd(3'd7, "R7");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule